// File: doc/BRIEF.md
# Lockable Two-Stage Watchdog Timer

This block is a memory-mapped watchdog with a plain register bus: a write strobe, a read strobe, a word address and 32-bit data. Software loads a reload value, enables the counter and must service the block before the count runs out. The counter steps down by one on every clock while enabled. Running out once raises an interrupt and starts a fresh countdown. Running out a second time while that interrupt is still pending asks for a system reset, provided the reset-enable bit is set. The request stays up until the block itself is reset.

Every configuration write is guarded. After reset the block is locked, and writes to any register other than the lock register are dropped. Software writes a fixed key to the lock register to open the block and writes any other value to close it again. Reads are always served. Servicing the watchdog is a single write to the interrupt-clear register. That write drops the pending interrupt and restarts the countdown from the reload value.

Top module: `wdg_top`

## Requirements
- R1: After reset the lock register reads 1, control reads 0, the interrupt and reset-request outputs are 0, and both the reload register and the counter read the reset reload value (0xFFFFFFFF by default).
- R2: Writing 0x1ACCE551 to the lock register (offset 0xC00) makes it read 0. The key also works when the block is already unlocked. Writing any other value makes bit 0 read 1.
- R3: While locked, writes to reload (0x000), control (0x008) and interrupt-clear (0x00C) change nothing.
- R4: Control (0x008) holds the enable in bit 0 and the reset-enable in bit 1. Bits 31:2 always read 0.
- R5: While enabled, the counter (read at 0x004) drops by one per clock. On the clock after it reads 0 it takes the reload value again, so one period lasts reload+1 clocks.
- R6: The first expiry sets the interrupt output, and the status register (0x014) reads 1 until the interrupt is cleared.
- R7: An expiry while the interrupt is still pending and reset-enable is 1 raises the reset request. The request stays at 1 until the reset input is asserted.
- R8: With reset-enable at 0, repeated expiries never raise the reset request, and the interrupt stays set.
- R9: An accepted write of any value to 0x00C clears the interrupt and reloads the counter. When this write lands in the same cycle as an expiry, the clear wins and no reset request is raised.
- R10: Clearing the enable bit freezes the counter. Setting it again from 0 reloads the counter on that write and resumes counting.
- R11: Reads are served whether the block is locked or not. Reads at 0x00C and at unmapped offsets return 0, and the read data is 0 while the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe |
| addr | input | 12 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr while rd_en is high |
| irq | output | 1 | Interrupt pending |
| rst_req | output | 1 | Sticky system reset request |

## Verification
Two events can fall on the same clock edge: a service write to the interrupt-clear register, and an expiry that would otherwise escalate to a reset request. The bench waits until its own model shows a zero count with the interrupt pending and reset enabled, then issues the clear in exactly that cycle. It judges the result by checking that the reset request stays low, that the interrupt drops and that the counter reads back the reload value. Beyond this case, a behavioural model updated on every edge is compared against the interrupt and reset-request outputs on every clock.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int OFF_RELOAD = 'h000;
  localparam int OFF_COUNT  = 'h004;
  localparam int OFF_CTRL   = 'h008;
  localparam int OFF_CLEAR  = 'h00C;
  localparam int OFF_STATUS = 'h014;
  localparam int OFF_LOCK   = 'hC00;

  localparam logic [31:0] UNLOCK_KEY = 32'h1ACCE551;

  // Next counter value for one clock of an enabled, un-serviced counter.
  function automatic logic [31:0] count_step(input logic [31:0] cur,
                                             input logic [31:0] reload);
    return (cur == '0) ? reload : cur - 32'd1;
  endfunction

  // A key write decides the lock state: key opens, anything else closes.
  function automatic logic lock_after(input logic [31:0] data);
    return data != UNLOCK_KEY;
  endfunction
endpackage

// File: rtl/wdg_regs.sv
module wdg_regs #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] RESET_LOAD = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              locked_o,
  output logic [DATA_W-1:0] reload_o,
  output logic              en_o,
  output logic              rst_en_o,
  output logic              clear_o,
  output logic              en_rise_o
);
  import wdg_pkg::*;

  logic locked_q, en_q, rst_en_q;
  logic [DATA_W-1:0] reload_q;

  // Named decode events
  logic hit_lock, wr_open, wr_reload, wr_ctrl;
  assign hit_lock  = wr_en && (addr == ADDR_W'(OFF_LOCK));
  assign wr_open   = wr_en && !locked_q;
  assign wr_reload = wr_open && (addr == ADDR_W'(OFF_RELOAD));
  assign wr_ctrl   = wr_open && (addr == ADDR_W'(OFF_CTRL));
  assign clear_o   = wr_open && (addr == ADDR_W'(OFF_CLEAR));
  assign en_rise_o = wr_ctrl && wdata[0] && !en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b1;
      reload_q <= RESET_LOAD;
      en_q     <= 1'b0;
      rst_en_q <= 1'b0;
    end else begin
      if (hit_lock) locked_q <= lock_after(32'(wdata));
      if (wr_reload) reload_q <= wdata;
      if (wr_ctrl) begin
        en_q     <= wdata[0];
        rst_en_q <= wdata[1];
      end
    end
  end

  assign locked_o = locked_q;
  assign reload_o = reload_q;
  assign en_o     = en_q;
  assign rst_en_o = rst_en_q;

  p_locked_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && wr_en && !hit_lock) |=> ($stable(reload_q) && $stable(en_q) && $stable(rst_en_q)));
  p_key_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_lock && (32'(wdata) == UNLOCK_KEY)) |=> !locked_q);
  p_other_closes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_lock && (32'(wdata) != UNLOCK_KEY)) |=> locked_q);
endmodule

// File: rtl/wdg_core.sv
module wdg_core #(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] RESET_LOAD = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              rst_en,
  input  logic [DATA_W-1:0] reload,
  input  logic              clear,
  input  logic              en_rise,
  output logic [DATA_W-1:0] count_o,
  output logic              pend_o,
  output logic              rst_req_o
);
  import wdg_pkg::*;

  logic [DATA_W-1:0] cnt_q;
  logic pend_q, rst_req_q;

  // Named internal events
  logic restart_ev, timeout_ev, escalate_ev;
  assign restart_ev  = clear || en_rise;
  assign timeout_ev  = en && !restart_ev && (cnt_q == '0);
  assign escalate_ev = timeout_ev && pend_q && rst_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= RESET_LOAD;
      pend_q    <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      if (restart_ev) cnt_q <= reload;
      else if (en)    cnt_q <= DATA_W'(count_step(32'(cnt_q), 32'(reload)));
      if (clear)           pend_q <= 1'b0;
      else if (timeout_ev) pend_q <= 1'b1;
      if (escalate_ev) rst_req_q <= 1'b1;
    end
  end

  assign count_o   = cnt_q;
  assign pend_o    = pend_q;
  assign rst_req_o = rst_req_q;

  p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !restart_ev && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_ev |=> (cnt_q == $past(reload)));
  p_irq_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_ev |=> pend_q);
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_q |=> rst_req_q);
  p_needs_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req_q) |-> $past(pend_q));
  p_needs_rsten_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req_q) |-> $past(rst_en));
  p_clear_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && !rst_req_q) |=> (!pend_q && !rst_req_q));
  p_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !restart_ev) |=> $stable(cnt_q));
endmodule

// File: rtl/wdg_top.sv
module wdg_top #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] RESET_LOAD = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic              rst_req
);
  import wdg_pkg::*;

  localparam int PAD_CTRL = DATA_W - 2;
  localparam int PAD_BIT  = DATA_W - 1;

  logic locked, en, rst_en, clear, en_rise, pend;
  logic [DATA_W-1:0] reload, count;

  wdg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RESET_LOAD(RESET_LOAD)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .locked_o(locked), .reload_o(reload), .en_o(en), .rst_en_o(rst_en),
    .clear_o(clear), .en_rise_o(en_rise)
  );

  wdg_core #(.DATA_W(DATA_W), .RESET_LOAD(RESET_LOAD)) u_core (
    .clk(clk), .rst_n(rst_n), .en(en), .rst_en(rst_en), .reload(reload),
    .clear(clear), .en_rise(en_rise), .count_o(count), .pend_o(pend),
    .rst_req_o(rst_req)
  );

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (addr == ADDR_W'(OFF_RELOAD))      rdata = reload;
      else if (addr == ADDR_W'(OFF_COUNT))  rdata = count;
      else if (addr == ADDR_W'(OFF_CTRL))   rdata = {{PAD_CTRL{1'b0}}, rst_en, en};
      else if (addr == ADDR_W'(OFF_STATUS)) rdata = {{PAD_BIT{1'b0}}, pend};
      else if (addr == ADDR_W'(OFF_LOCK))   rdata = {{PAD_BIT{1'b0}}, locked};
    end
  end

  assign irq = pend;

  p_read_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rdata == '0));
endmodule

// File: tb/test_wdg_top.sv
module test_wdg_top;
  localparam logic [31:0] KEY = 32'h1ACCE551;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq, rst_req;

  int n_cmp = 0, n_bad = 0, cycles = 0;
  bit done = 0;

  wdg_top i_wdg_top (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .rst_req(rst_req));

  always #10 clk = ~clk;

  // Behavioural reference model
  bit m_locked = 1, m_en = 0, m_rsten = 0, m_pend = 0, m_req = 0;
  longint m_load = 64'hFFFF_FFFF, m_cnt = 64'hFFFF_FFFF;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_locked = 1; m_en = 0; m_rsten = 0; m_pend = 0; m_req = 0;
      m_load = 64'hFFFF_FFFF; m_cnt = 64'hFFFF_FFFF;
    end else begin
      bit was_locked, was_en, was_rsten, was_pend, open, svc, start;
      longint was_load, was_cnt;
      was_locked = m_locked; was_en = m_en; was_rsten = m_rsten;
      was_pend = m_pend; was_load = m_load; was_cnt = m_cnt;
      open = wr_en && !was_locked;
      svc = open && addr == 12'h00C;
      start = open && addr == 12'h008 && wdata[0] && !was_en;
      if (wr_en && addr == 12'hC00) m_locked = (wdata != KEY);
      if (open && addr == 12'h000) m_load = wdata;
      if (open && addr == 12'h008) begin m_en = wdata[0]; m_rsten = wdata[1]; end
      if (svc || start) begin
        m_cnt = was_load;
        if (svc) m_pend = 0;
      end else if (was_en) begin
        if (was_cnt == 0) begin
          m_cnt = was_load;
          if (was_pend && was_rsten) m_req = 1;
          m_pend = 1;
        end else m_cnt = was_cnt - 1;
      end
    end
  end

  function automatic longint model_read(input logic [11:0] a);
    case (a)
      12'h000: return m_load;
      12'h004: return m_cnt;
      12'h008: return {m_rsten, m_en};
      12'h014: return m_pend;
      12'hC00: return m_locked;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Every clock: outputs against the model (R5, R6, R7, R8, R9 streams)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R6 irq vs model", irq, m_pend);
      check("R7 rst_req vs model", rst_req, m_req);
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0; addr = '0; wdata = '0;
  endtask

  task automatic rd(input string tag, input logic [11:0] a, input longint exp);
    rd_en = 1; addr = a;
    #1;
    check(tag, rdata, exp);
    check({tag, " (model)"}, rdata, model_read(a));
    rd_en = 0; addr = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0;
    idle(2);
    rst_n = 1;
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_bad++;
      $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    longint frozen;
    @(negedge clk);
    do_reset();
    // R1 reset state
    rd("R1 lock", 12'hC00, 1);
    rd("R1 ctrl", 12'h008, 0);
    rd("R1 reload", 12'h000, 64'hFFFF_FFFF);
    rd("R1 count", 12'h004, 64'hFFFF_FFFF);
    check("R1 irq", irq, 0);
    check("R1 rst_req", rst_req, 0);
    // R3 writes ignored while locked; R11 reads served while locked
    wr(12'h000, 32'd5);
    wr(12'h008, 32'h3);
    wr(12'h00C, 32'h1);
    rd("R3 reload kept", 12'h000, 64'hFFFF_FFFF);
    rd("R3 ctrl kept", 12'h008, 0);
    rd("R11 count while locked", 12'h004, 64'hFFFF_FFFF);
    // R2 lock behaviour
    wr(12'hC00, 32'h1ACCE550);
    rd("R2 wrong key", 12'hC00, 1);
    wr(12'hC00, KEY);
    rd("R2 key opens", 12'hC00, 0);
    wr(12'hC00, KEY);
    rd("R2 key again", 12'hC00, 0);
    wr(12'hC00, 32'h0);
    rd("R2 relock", 12'hC00, 1);
    wr(12'hC00, KEY);
    // R11 write-only and unmapped read zero
    rd("R11 clear reads zero", 12'h00C, 0);
    rd("R11 unmapped zero", 12'h010, 0);
    // R4 control bits
    wr(12'h000, 32'd5);
    wr(12'h008, 32'hFFFF_FFFE);
    rd("R4 reserved zero", 12'h008, 2);
    // R10 re-enable reloads, R5 counting
    wr(12'h008, 32'h3);
    rd("R10 enable reloads", 12'h004, 5);
    idle(2);
    rd("R5 two steps", 12'h004, 3);
    idle(4);
    rd("R5 wrapped", 12'h004, 5);
    check("R6 irq after first expiry", irq, 1);
    rd("R6 status", 12'h014, 1);
    // R9 clear in the same cycle as an escalating expiry
    while (m_cnt != 0) @(negedge clk);
    check("R9 setup pending", irq, 1);
    wr(12'h00C, 32'h0);
    check("R9 no reset on collision", rst_req, 0);
    check("R9 irq cleared", irq, 0);
    rd("R9 reloaded", 12'h004, 5);
    // R7 two expiries escalate; sticky
    idle(20);
    check("R7 reset raised", rst_req, 1);
    wr(12'h00C, 32'h0);
    idle(10);
    check("R7 reset sticky", rst_req, 1);
    do_reset();
    check("R7 reset cleared by rst_n", rst_req, 0);
    // R8 no reset without reset-enable
    wr(12'hC00, KEY);
    wr(12'h000, 32'd3);
    wr(12'h008, 32'h1);
    idle(40);
    check("R8 no reset", rst_req, 0);
    check("R8 irq held", irq, 1);
    // R10 freeze
    wr(12'h008, 32'h0);
    rd("R10 frozen read", 12'h004, m_cnt);
    frozen = m_cnt;
    idle(7);
    rd("R10 still frozen", 12'h004, frozen);
    wr(12'h000, 32'd9);
    wr(12'h008, 32'h1);
    rd("R10 restart value", 12'h004, 9);
    idle(3);
    finish_run();
  end
endmodule